// File: doc/BRIEF.md
# Prescaled Protocol Timer with Watchdog Reset

This block is an 8-bit down-counting timer for low-resolution protocol timing, such as link-layer retransmission and idle timers. The master clock feeds a prescaler with a selectable ratio of 2, 4, 8 or 16. A fixed divider follows it, which is 1024 by default, and its output steps the counter. The host writes and reads the count, a control register and a status register through a flat register port. A host write to the count loads the new value and restarts the whole prescale interval. The control register holds the run enable, the prescale code and the watchdog mode bit.

An interrupt event happens when the counter steps from FF down to FE, and the counter keeps counting after it. The event sets a sticky status bit. The host may clear that bit only after it has read the bit while it was set. In watchdog mode an extra divider, 16 by default, lengthens every counter step. The same FF-to-FE step also drives an active-low reset output for a fixed number of master-clock cycles, 16 by default. In watchdog mode the value FE cannot be written to the count.

Top module: `proto_timer`

## Requirements
- R1: With run enabled and watchdog mode off, the counter decrements once every (2 << code) × FIX_DIV master-clock cycles. The code is control bits 2:1, so codes 0, 1, 2 and 3 give ratios 2, 4, 8 and 16. Control bit 0 is run.
- R2: A write to register select 0 loads any 8-bit value into the count, and a read of select 0 returns it. The load restarts the prescale chain, so the next decrement comes one full interval after the write.
- R3: The step from FF to FE sets status bit 0 (register select 2) in the same edge. Counting goes on, including the wrap from 00 to FF.
- R4: Writing 1 to status bit 0 clears it only if a read of the status register (rd_en with select 2) was made while the bit was set. A clear attempt with no such read, or one after a read that returned 0, leaves the bit set.
- R5: When run is 0, the count holds its value and irq is low even while the status bit is set. When run is 1, irq follows the status bit.
- R6: With control bit 3 (watchdog) set, every counter step takes WD_DIV times longer than in R1.
- R7: In watchdog mode, the FF-to-FE step drives wdt_rst_n low from that edge for exactly RST_CYC master-clock cycles.
- R8: In watchdog mode, a write of FE to the count is ignored and the previous value is kept. Outside watchdog mode, FE loads normally.
- R9: After reset, the count, control and status all read 0, irq is low and wdt_rst_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 count, 1 control, 2 status |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; marks a status read for the clear handshake |
| rd_data | output | 8 | Contents of the selected register |
| irq | output | 1 | Status bit gated by run |
| wdt_rst_n | output | 1 | Active-low watchdog reset pulse |

## Verification
A prescale stage that is off by one shows up as a count that changes one cycle early or late, so every step time is checked on both sides of the expected edge. A broken read-then-clear handshake shows up at the next status write: the bit either clears too easily or never clears. A wrong reset-pulse counter shows up within RST_CYC cycles of the watchdog underflow, as a pulse that is too short or too long. A filter on the FE write that does not work shows up in the very next read of the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SEL_COUNT = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_NONE  = 2'd3
   } tmr_sel_e;

   typedef struct packed {
      logic       wdog;
      logic [1:0] pre;
      logic       run;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W   = 2,
   parameter int FIX_DIV = 1024,
   parameter int WD_DIV  = 16,
   parameter bit WD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [PRE_W-1:0] pre_code,
   input  logic             wd_mode,
   output logic             tick
);
   localparam int S1_W = (1 << PRE_W) + 1;
   localparam int S2_W = $clog2(FIX_DIV);

   logic [S1_W-1:0] cnt1, lim1;
   logic [S2_W-1:0] cnt2;
   logic            p1, p2, hold;

   assign hold = clr | ~run;
   assign lim1 = (S1_W'(2) << pre_code) - S1_W'(1);
   assign p1   = run && (cnt1 >= lim1);
   assign p2   = p1 && (cnt2 == S2_W'(FIX_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt1 <= '0;
      else if (hold)    cnt1 <= '0;
      else if (p1)      cnt1 <= '0;
      else              cnt1 <= cnt1 + S1_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt2 <= '0;
      else if (hold)    cnt2 <= '0;
      else if (p2)      cnt2 <= '0;
      else if (p1)      cnt2 <= cnt2 + S2_W'(1);
   end

   generate
      if (WD_EN) begin : g_wd
         localparam int S3_W = $clog2(WD_DIV);
         logic [S3_W-1:0] cnt3;
         logic            p3;
         assign p3 = p2 && (!wd_mode || (cnt3 == S3_W'(WD_DIV - 1)));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt3 <= '0;
            else if (hold || !wd_mode) cnt3 <= '0;
            else if (p3)              cnt3 <= '0;
            else if (p2)              cnt3 <= cnt3 + S3_W'(1);
         end
         assign tick = p3;
      end else begin : g_plain
         logic unused_wd;
         assign unused_wd = wd_mode;
         assign tick = p2;
      end
   endgenerate

   // every ratio is at least 2*FIX_DIV, so ticks never come back to back
   assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // a restart request leaves no tick in the following cycle
   assert_clr_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   assign wrap = tick && !ld && (cnt == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (ld)   cnt <= ld_val;
      else if (tick) cnt <= cnt - W'(1);
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == $past(ld_val));
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld) |=> cnt == $past(cnt) - W'(1));
   assert_wrap_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == {{(W-1){1'b1}}, 1'b0});
endmodule

// File: rtl/tmr_rstpulse.sv
module tmr_rstpulse #(
   parameter int CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic rst_o_n
);
   localparam int RW = $clog2(CYC + 1);
   logic [RW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left <= '0;
      else if (trig)           left <= RW'(CYC);
      else if (left != '0)     left <= left - RW'(1);
   end

   assign rst_o_n = (left == '0);

   assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !rst_o_n);
   assert_pulse_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_o_n) |=> !rst_o_n);
endmodule

// File: rtl/proto_timer.sv
module proto_timer #(
   parameter int CNT_W   = 8,
   parameter int FIX_DIV = 1024,
   parameter int WD_DIV  = 16,
   parameter int RST_CYC = 16,
   parameter bit WDOG_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_sel,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rd_en,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq,
   output logic             wdt_rst_n
);
   import tmr_pkg::*;

   localparam logic [CNT_W-1:0] FE_VAL = {{(CNT_W-1){1'b1}}, 1'b0};

   initial begin
      assert (CNT_W >= 4)   else $error("CNT_W must hold the control fields");
      assert (FIX_DIV >= 2) else $error("FIX_DIV must be at least 2");
      assert (WD_DIV >= 2)  else $error("WD_DIV must be at least 2");
      assert (RST_CYC >= 2) else $error("RST_CYC must be at least 2");
   end

   tmr_ctrl_t        ctrl_q;
   logic             stat_q, armed_q;
   logic [CNT_W-1:0] cnt;
   logic             tick, wrap, ld, fe_block;
   logic             wr_cnt, wr_ctl, wr_stat, rd_stat;

   assign wr_cnt   = wr_en && (reg_sel == SEL_COUNT);
   assign wr_ctl   = wr_en && (reg_sel == SEL_CTRL);
   assign wr_stat  = wr_en && (reg_sel == SEL_STAT);
   assign rd_stat  = rd_en && (reg_sel == SEL_STAT);
   assign fe_block = ctrl_q.wdog && (wr_data == FE_VAL);
   assign ld       = wr_cnt && !fe_block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctl) begin
         ctrl_q.run  <= wr_data[0];
         ctrl_q.pre  <= wr_data[2:1];
         ctrl_q.wdog <= WDOG_EN ? wr_data[3] : 1'b0;
      end
   end

   tmr_prescale #(.PRE_W(2), .FIX_DIV(FIX_DIV), .WD_DIV(WD_DIV), .WD_EN(WDOG_EN)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(ld), .run(ctrl_q.run),
      .pre_code(ctrl_q.pre), .wd_mode(ctrl_q.wdog), .tick(tick));

   tmr_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ld_val(wr_data),
      .cnt(cnt), .wrap(wrap));

   // sticky status with read-while-set before clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (wr_stat && wr_data[0] && armed_q) begin
         stat_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (!stat_q) begin
         stat_q  <= wrap;
         armed_q <= 1'b0;
      end else if (rd_stat) begin
         armed_q <= 1'b1;
      end
   end

   assign irq = stat_q && ctrl_q.run;

   generate
      if (WDOG_EN) begin : g_wdog
         tmr_rstpulse #(.CYC(RST_CYC)) u_rst (
            .clk(clk), .rst_n(rst_n), .trig(wrap && ctrl_q.wdog), .rst_o_n(wdt_rst_n));
      end else begin : g_nowdog
         assign wdt_rst_n = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (reg_sel)
         SEL_COUNT: rd_data = cnt;
         SEL_CTRL:  rd_data = CNT_W'(ctrl_q);
         SEL_STAT:  rd_data = CNT_W'(stat_q);
         default:   rd_data = '0;
      endcase
   end

   assert_clear_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !armed_q) |=> stat_q);
   assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !ld) |=> $stable(cnt));
   assert_fe_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cnt && fe_block && !tick) |=> $stable(cnt));
   assert_status_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> stat_q);
endmodule

// File: tb/sim_proto_timer.sv
`timescale 1ns/1ps
module sim_proto_timer;
   localparam int FIXD = 4;
   localparam int WDD  = 4;
   localparam int RSTC = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq, wdt_rst_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   proto_timer #(.CNT_W(8), .FIX_DIV(FIXD), .WD_DIV(WDD), .RST_CYC(RSTC), .WDOG_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .wdt_rst_n(wdt_rst_n));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] sel, output logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] sel, output logic [7:0] d);
      reg_sel = sel;
      #1 d = rd_data;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clean_status();
      logic [7:0] d;
      do_read(2'd2, d);
      do_write(2'd2, 8'h01);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      peek(2'd0, d); chk("R9 count after reset", d, 8'h00);
      peek(2'd1, d); chk("R9 control after reset", d, 8'h00);
      peek(2'd2, d); chk("R9 status after reset", d, 8'h00);
      chk("R9 irq after reset", irq, 1'b0);
      chk("R9 wdt_rst_n after reset", wdt_rst_n, 1'b1);
   endtask

   task automatic t_rw();
      logic [7:0] d;
      do_write(2'd0, 8'hA5); peek(2'd0, d); chk("R2 count readback A5", d, 8'hA5);
      do_write(2'd0, 8'h3C); peek(2'd0, d); chk("R2 count readback 3C", d, 8'h3C);
      do_write(2'd1, 8'h06); peek(2'd1, d); chk("R2 control readback", d, 8'h06);
      do_write(2'd1, 8'h00);
   endtask

   task automatic t_rate(input logic [1:0] code);
      logic [7:0] d;
      int p;
      p = (2 << code) * FIXD;
      do_write(2'd1, {5'b0, code, 1'b1});
      do_write(2'd0, 8'h40);
      wait_cyc(p - 1); peek(2'd0, d); chk($sformatf("R1 code %0d before step", code), d, 8'h40);
      wait_cyc(1);     peek(2'd0, d); chk($sformatf("R1 code %0d at step", code), d, 8'h3F);
      wait_cyc(p);     peek(2'd0, d); chk($sformatf("R1 code %0d second step", code), d, 8'h3E);
      do_write(2'd1, 8'h00);
   endtask

   task automatic t_restart();
      logic [7:0] d;
      do_write(2'd1, 8'h01);
      do_write(2'd0, 8'h20);
      wait_cyc(5);
      do_write(2'd0, 8'h20);
      wait_cyc(7); peek(2'd0, d); chk("R2 restart holds full interval", d, 8'h20);
      wait_cyc(1); peek(2'd0, d); chk("R2 restart step after interval", d, 8'h1F);
      do_write(2'd1, 8'h00);
   endtask

   task automatic t_underflow();
      logic [7:0] d;
      do_write(2'd1, 8'h01);
      do_write(2'd0, 8'h01);
      wait_cyc(23); peek(2'd0, d); chk("R3 wrap 00 to FF", d, 8'hFF);
      peek(2'd2, d); chk("R3 no status before FF->FE", d, 8'h00);
      wait_cyc(1); peek(2'd2, d); chk("R3 status at FF->FE", d, 8'h01);
      peek(2'd0, d); chk("R3 count FE", d, 8'hFE);
      chk("R5 irq follows status", irq, 1'b1);
      wait_cyc(8); peek(2'd0, d); chk("R3 keeps counting", d, 8'hFD);
   endtask

   task automatic t_handshake();
      logic [7:0] d;
      do_write(2'd2, 8'h01); peek(2'd2, d); chk("R4 clear without read ignored", d, 8'h01);
      do_read(2'd2, d); chk("R4 read returns set", d, 8'h01);
      do_write(2'd2, 8'h01); peek(2'd2, d); chk("R4 clear after read", d, 8'h00);
      chk("R4 irq low after clear", irq, 1'b0);
      do_read(2'd2, d);
      do_write(2'd0, 8'hFF);
      wait_cyc(8); peek(2'd2, d); chk("R3 second event sets status", d, 8'h01);
      do_write(2'd2, 8'h01); peek(2'd2, d); chk("R4 read while clear does not arm", d, 8'h01);
   endtask

   task automatic t_disable();
      logic [7:0] d, c0;
      do_write(2'd1, 8'h00);
      peek(2'd0, c0);
      chk("R5 irq low when run off", irq, 1'b0);
      peek(2'd2, d); chk("R5 status kept when run off", d, 8'h01);
      wait_cyc(60); peek(2'd0, d); chk("R5 count frozen when run off", d, c0);
      do_write(2'd1, 8'h01);
      chk("R5 irq back with run on", irq, 1'b1);
      do_write(2'd1, 8'h00);
      clean_status();
   endtask

   task automatic t_watchdog();
      logic [7:0] d;
      int p;
      p = 2 * FIXD * WDD;
      do_write(2'd1, 8'h09);
      do_write(2'd0, 8'hFF);
      wait_cyc(p - 1); peek(2'd0, d); chk("R6 slow step not yet", d, 8'hFF);
      chk("R7 reset high before event", wdt_rst_n, 1'b1);
      wait_cyc(1); peek(2'd0, d); chk("R6 step after WD interval", d, 8'hFE);
      chk("R7 reset low at event", wdt_rst_n, 1'b0);
      peek(2'd2, d); chk("R3 status in watchdog mode", d, 8'h01);
      wait_cyc(RSTC - 1); chk("R7 reset low at last cycle", wdt_rst_n, 1'b0);
      wait_cyc(1); chk("R7 reset released after pulse", wdt_rst_n, 1'b1);
      do_write(2'd0, 8'h90);
      do_write(2'd0, 8'hFE); peek(2'd0, d); chk("R8 FE write ignored in watchdog", d, 8'h90);
      do_write(2'd1, 8'h01);
      do_write(2'd0, 8'hFE); peek(2'd0, d); chk("R8 FE write accepted otherwise", d, 8'hFE);
      do_write(2'd1, 8'h00);
      clean_status();
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_rate(2'd0);
      t_rate(2'd2);
      t_rate(2'd3);
      t_restart();
      t_underflow();
      t_handshake();
      t_disable();
      t_watchdog();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired before tests completed");
         finish_run();
      end
   end
endmodule